// File: doc/BRIEF.md
# E1 Remote Alarm and Far-End Block Error Generator

This block decides two pieces of information for the spare positions of the outgoing E1 timeslot-0 words. The first is the remote alarm bit, sent in the non-alignment frames. The second is the pair of far-end block error bits, sent in frames 13 and 15 of the CRC-4 multiframe. It does no framing of its own. It takes level flags from the receive side (basic frame lost, AIS seen, CRC-4 interworking, offline search out of frame, CRC-4 multiframe lost) and single-cycle CRC error pulses, one for each received sub-multiframe. It turns these into bits that the transmit framer picks up.

The alarm bit follows one of four policies, chosen by a 2-bit control. Each received CRC error is latched for its own sub-multiframe. The transmitter consumes it with a sample pulse at the transmit multiframe boundary, so each error is reported exactly once. While multiframe lock is lost, both error bits carry a programmable constant. A disable control removes the error reporting altogether.

Top module: `e1_rai_gen`

## Requirements
- R1: In the cycle after a synchronous reset, `rai_o` is 0 and `e_bits_o` is 2'b11.
- R2: With `cfg_rai_mode` = 2'b11 (forced), `rai_o` is 1 whatever the alarm flags are.
- R3: With `cfg_rai_mode` = 2'b01 (four-condition policy), `rai_o` is 1 exactly when at least one of `st_lobf`, `st_ais`, `st_interwork` or `st_offline_oof` is 1.
- R4: With `cfg_rai_mode` = 2'b10 (two-condition policy), `rai_o` is 1 exactly when `st_lobf` or `st_ais` is 1. `st_interwork` and `st_offline_oof` have no effect.
- R5: With `cfg_rai_mode` = 2'b00 (off), `rai_o` is 0 whatever the alarm flags are.
- R6: `rai_o` is registered. It shows the policy result for the mode and flags present at the previous rising clock edge.
- R7: `e_bits_o[0]` is the E1 bit and `e_bits_o[1]` is the E2 bit. A pulse on `crc_err_smf1` makes E1 read 0 from the next cycle on, and a pulse on `crc_err_smf2` does the same for E2. Each bit is affected only by its own pulse.
- R8: A latched error stays visible until a cycle with `tx_mf_sample` = 1. After that cycle the bit reads 1 again. If an error pulse arrives in the same cycle as the sample, it is kept for the next multiframe.
- R9: While neither error latch is set, lock is held and reporting is enabled, both E bits read 1.
- R10: While `st_lomf` = 1 (and reporting is enabled), both E bits equal `cfg_oom_e_val`, in the same cycle. Pending errors are discarded, so after lock returns the bits read 1 until a new error arrives.
- R11: While `cfg_febe_off` = 1, `e_bits_o` is 2'b11. Error pulses are ignored, and none is reported once reporting is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rai_mode | input | 2 | Alarm policy: 00 off, 01 four-condition, 10 two-condition, 11 forced |
| cfg_febe_off | input | 1 | 1 disables far-end block error reporting |
| cfg_oom_e_val | input | 1 | Value of both E bits while multiframe lock is lost |
| st_lobf | input | 1 | Receive basic frame alignment lost |
| st_ais | input | 1 | Receive AIS detected |
| st_interwork | input | 1 | CRC-4 to non-CRC-4 interworking in effect |
| st_offline_oof | input | 1 | Offline frame search is out of basic frame |
| st_lomf | input | 1 | Receive CRC-4 multiframe lock lost |
| crc_err_smf1 | input | 1 | One-cycle pulse: CRC error in received sub-multiframe I |
| crc_err_smf2 | input | 1 | One-cycle pulse: CRC error in received sub-multiframe II |
| tx_mf_sample | input | 1 | One-cycle pulse: transmitter has taken the E bits |
| rai_o | output | 1 | Remote alarm bit for transmission |
| e_bits_o | output | 2 | E bits; bit 0 is E1, bit 1 is E2 |

## Verification
A wrong alarm-policy decode shows on `rai_o` one cycle after the flags change, so the bench walks each flag through each mode separately. A bad error latch shows in one of three ways: an error that is lost (an E bit that goes back to 1 before any sample pulse), an error that is counted twice (a 0 that survives a sample), or an error steered to the wrong bit. Each of these is visible on `e_bits_o` within a cycle of the pulse or the sample. A flush that does not happen during lost lock or during disable shows only after the condition ends, as a stale 0, so the bench checks the bits right after lock returns and right after reporting is enabled again.

// File: rtl/e1_rai_pkg.sv
package e1_rai_pkg;

    typedef enum logic [1:0] {
        RAI_OFF    = 2'b00,
        RAI_ETSI   = 2'b01,
        RAI_ANNEXB = 2'b10,
        RAI_FORCE  = 2'b11
    } rai_mode_e;

    typedef struct packed {
        logic lobf;
        logic ais;
        logic interwork;
        logic offline_oof;
    } rx_alarm_t;

    localparam int SMF_PER_MF = 2;

    function automatic logic rai_decide(rai_mode_e mode, rx_alarm_t a);
        logic r;
        case (mode)
            RAI_FORCE:  r = 1'b1;
            RAI_ETSI:   r = a.lobf | a.ais | a.interwork | a.offline_oof;
            RAI_ANNEXB: r = a.lobf | a.ais;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/e1_rai_policy.sv
module e1_rai_policy
    import e1_rai_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rai_mode_e mode,
    input  rx_alarm_t alarm,
    output logic      rai_o
);

    always_ff @(posedge clk) begin
        if (rst) rai_o <= 1'b0;
        else     rai_o <= rai_decide(mode, alarm);
    end

    AST_RAI_FORCED: assert property (@(posedge clk) disable iff (rst)
        (mode == RAI_FORCE) |=> rai_o); // R2

    AST_RAI_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode == RAI_OFF) |=> !rai_o); // R5

    AST_RAI_TWO_COND: assert property (@(posedge clk) disable iff (rst)
        (mode == RAI_ANNEXB && !alarm.lobf && !alarm.ais) |=> !rai_o); // R4

    AST_RAI_FOUR_COND: assert property (@(posedge clk) disable iff (rst)
        (mode == RAI_ETSI && (alarm.interwork || alarm.offline_oof)) |=> rai_o); // R3

endmodule

// File: rtl/e1_febe_slot.sv
module e1_febe_slot (
    input  logic clk,
    input  logic rst,
    input  logic err_pulse,
    input  logic sample,
    input  logic flush,
    output logic err_q
);

    always_ff @(posedge clk) begin
        if (rst || flush) err_q <= 1'b0;
        else              err_q <= err_pulse | (err_q & ~sample);
    end

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        (err_q && !sample && !flush) |=> err_q); // R8

    AST_ERR_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (err_q && sample && !err_pulse) |=> !err_q); // R8

endmodule

// File: rtl/e1_rai_gen.sv
module e1_rai_gen
    import e1_rai_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_rai_mode,
    input  logic       cfg_febe_off,
    input  logic       cfg_oom_e_val,
    input  logic       st_lobf,
    input  logic       st_ais,
    input  logic       st_interwork,
    input  logic       st_offline_oof,
    input  logic       st_lomf,
    input  logic       crc_err_smf1,
    input  logic       crc_err_smf2,
    input  logic       tx_mf_sample,
    output logic       rai_o,
    output logic [1:0] e_bits_o
);

    rx_alarm_t                alarm;
    logic [SMF_PER_MF-1:0]    err_in;
    logic [SMF_PER_MF-1:0]    err_pend;
    logic                     flush;

    assign alarm  = '{lobf: st_lobf, ais: st_ais,
                      interwork: st_interwork, offline_oof: st_offline_oof};
    assign err_in = {crc_err_smf2, crc_err_smf1};
    assign flush  = st_lomf | cfg_febe_off;

    e1_rai_policy u_policy (
        .clk   (clk),
        .rst   (rst),
        .mode  (rai_mode_e'(cfg_rai_mode)),
        .alarm (alarm),
        .rai_o (rai_o)
    );

    for (genvar i = 0; i < SMF_PER_MF; i++) begin : g_smf
        e1_febe_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .err_pulse (err_in[i]),
            .sample    (tx_mf_sample),
            .flush     (flush),
            .err_q     (err_pend[i])
        );
    end

    always_comb begin
        if (cfg_febe_off)  e_bits_o = '1;
        else if (st_lomf)  e_bits_o = {SMF_PER_MF{cfg_oom_e_val}};
        else               e_bits_o = ~err_pend;
    end

    AST_E1_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (crc_err_smf1 && !flush) |=> (!e_bits_o[0] || flush)); // R7

    AST_E2_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (crc_err_smf2 && !flush) |=> (!e_bits_o[1] || flush)); // R7

    AST_E_RELOCK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (st_lomf && !crc_err_smf1 && !crc_err_smf2) |=> (st_lomf || cfg_febe_off || e_bits_o == 2'b11)); // R10

endmodule

// File: tb/e1_rai_gen_test.sv
module e1_rai_gen_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_rai_mode;
    logic       cfg_febe_off, cfg_oom_e_val;
    logic       st_lobf, st_ais, st_interwork, st_offline_oof, st_lomf;
    logic       crc_err_smf1, crc_err_smf2, tx_mf_sample;
    logic       rai_o;
    logic [1:0] e_bits_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_rai_gen uut (
        .clk(clk), .rst(rst), .cfg_rai_mode(cfg_rai_mode),
        .cfg_febe_off(cfg_febe_off), .cfg_oom_e_val(cfg_oom_e_val),
        .st_lobf(st_lobf), .st_ais(st_ais), .st_interwork(st_interwork),
        .st_offline_oof(st_offline_oof), .st_lomf(st_lomf),
        .crc_err_smf1(crc_err_smf1), .crc_err_smf2(crc_err_smf2),
        .tx_mf_sample(tx_mf_sample), .rai_o(rai_o), .e_bits_o(e_bits_o)
    );

    task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_flags(logic [3:0] f);
        {st_lobf, st_ais, st_interwork, st_offline_oof} = f;
    endtask

    function automatic logic model_rai(logic [1:0] m, logic [3:0] f);
        case (m)
            2'b11:   return 1'b1;
            2'b01:   return |f;
            2'b10:   return f[3] | f[2];
            default: return 1'b0;
        endcase
    endfunction

    task automatic test_reset();
        rst = 1'b1; cfg_rai_mode = 2'b11; cfg_febe_off = 1'b0; cfg_oom_e_val = 1'b0;
        set_flags(4'b0000); st_lomf = 1'b0;
        crc_err_smf1 = 1'b1; crc_err_smf2 = 1'b1; tx_mf_sample = 1'b0;
        step(); step();
        chk("R1 rai", {1'b0, rai_o}, 2'b00);
        chk("R1 ebits", e_bits_o, 2'b11);
        crc_err_smf1 = 1'b0; crc_err_smf2 = 1'b0;
        rst = 1'b0;
        cfg_rai_mode = 2'b00;
        step();
        chk("R9 idle ebits", e_bits_o, 2'b11);
    endtask

    task automatic test_rai_modes();
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 16; f++) begin
                cfg_rai_mode = m[1:0];
                set_flags(f[3:0]);
                step();
                case (m)
                    0: chk("R5 off", {1'b0, rai_o}, {1'b0, model_rai(m[1:0], f[3:0])});
                    1: chk("R3 four-cond", {1'b0, rai_o}, {1'b0, model_rai(m[1:0], f[3:0])});
                    2: chk("R4 two-cond", {1'b0, rai_o}, {1'b0, model_rai(m[1:0], f[3:0])});
                    default: chk("R2 forced", {1'b0, rai_o}, {1'b0, model_rai(m[1:0], f[3:0])});
                endcase
            end
        end
    endtask

    task automatic test_rai_latency();
        cfg_rai_mode = 2'b10; set_flags(4'b0000);
        step();
        set_flags(4'b1000);
        #1;
        chk("R6 before edge", {1'b0, rai_o}, 2'b00);
        step();
        chk("R6 after edge", {1'b0, rai_o}, 2'b01);
        set_flags(4'b0011);
        step();
        chk("R4 ignored flags", {1'b0, rai_o}, 2'b00);
        set_flags(4'b0000);
    endtask

    task automatic test_e_bits();
        crc_err_smf1 = 1'b1; step(); crc_err_smf1 = 1'b0;
        chk("R7 E1 only", e_bits_o, 2'b10);
        step(); step();
        chk("R8 held", e_bits_o, 2'b10);
        crc_err_smf2 = 1'b1; step(); crc_err_smf2 = 1'b0;
        chk("R7 E2 too", e_bits_o, 2'b00);
        tx_mf_sample = 1'b1; step(); tx_mf_sample = 1'b0;
        chk("R8 consumed", e_bits_o, 2'b11);
        tx_mf_sample = 1'b1; crc_err_smf2 = 1'b1; step();
        tx_mf_sample = 1'b0; crc_err_smf2 = 1'b0;
        chk("R8 same-cycle kept", e_bits_o, 2'b01);
        tx_mf_sample = 1'b1; step(); tx_mf_sample = 1'b0;
        chk("R9 clear", e_bits_o, 2'b11);
    endtask

    task automatic test_lomf();
        crc_err_smf1 = 1'b1; step(); crc_err_smf1 = 1'b0;
        st_lomf = 1'b1; cfg_oom_e_val = 1'b1;
        #1;
        chk("R10 oom=1", e_bits_o, 2'b11);
        cfg_oom_e_val = 1'b0;
        #1;
        chk("R10 oom=0", e_bits_o, 2'b00);
        crc_err_smf2 = 1'b1; step(); crc_err_smf2 = 1'b0;
        step();
        st_lomf = 1'b0;
        #1;
        chk("R10 relock clean", e_bits_o, 2'b11);
    endtask

    task automatic test_febe_off();
        crc_err_smf2 = 1'b1; step(); crc_err_smf2 = 1'b0;
        cfg_febe_off = 1'b1;
        #1;
        chk("R11 disabled", e_bits_o, 2'b11);
        crc_err_smf1 = 1'b1; st_lomf = 1'b1; step(); crc_err_smf1 = 1'b0;
        chk("R11 disabled over lomf", e_bits_o, 2'b11);
        st_lomf = 1'b0; step();
        cfg_febe_off = 1'b0;
        #1;
        chk("R11 no stale error", e_bits_o, 2'b11);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_rai_modes();
                test_rai_latency();
                test_e_bits();
                test_lomf();
                test_febe_off();
            end
            begin
                repeat (20000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule